// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives characters from an asynchronous serial line. It is clocked by the system clock and advances only on a one-cycle enable tick that runs at a fixed multiple of the bit rate, sixteen by default. The line first passes through a two-flop synchronizer. When the receiver sees the line low in idle, it treats that as a possible start bit. Half a bit time later it samples the line again and accepts the start bit only if the line is still low. After that, each data bit, the optional parity bit and the single stop bit are each sampled once, at the middle of the bit.

When a character is complete, it is copied from the assembly register into a holding buffer, and a full flag is raised. A read strobe from the consumer clears the full flag and the error flags that belong to the character. If the stop bit is sampled low, a framing status output rises. It stays high until the line is seen high again. While it is high, the receiver does not look for a new start bit.

The character length is selectable: a short character one bit narrower than the buffer, a standard character as wide as the buffer, or a long character with one extra bit. The extra bit is delivered on its own output. Parity applies only to the short and standard lengths.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, buf_full, par_err, ovr_err and frm_stat are 0, rd_data is 0 and rd_bit9 is 0.
- R2: A low on the line that ends before half a bit time (8 ticks) after it was seen is rejected. No character is loaded and frm_stat stays 0.
- R3: With fmt=2'b00 (or 2'b11), 8 data bits are received least significant bit first. In the cycle after the stop bit is sampled, rd_data holds the character and buf_full is 1.
- R4: With fmt=2'b01, 7 data bits are received least significant bit first, and rd_data[7] reads 0.
- R5: With fmt=2'b10, 9 data bits are received. Bits 0 to 7 appear on rd_data and bit 8 appears on rd_bit9. Parity is neither expected nor checked in this mode, so par_err stays 0 even when par_en=1.
- R6: With par_en=1 in 7- or 8-bit mode, a parity bit follows the data. For par_odd=0 the data bits plus the parity bit must hold an even number of ones; for par_odd=1 they must hold an odd number. On a mismatch, par_err is loaded as 1 together with the buffer.
- R7: A one-cycle rd_stb clears buf_full, par_err and ovr_err in the next cycle.
- R8: If a character completes while buf_full is still 1 and no read is made, the buffer takes the new character and ovr_err becomes 1.
- R9: If the stop bit is sampled low, frm_stat becomes 1 and stays 1 while the line stays low. No new start is detected during that low. frm_stat returns to 0 within a few cycles of the line going high.
- R10: Exactly one stop bit is required. A character whose stop bit is directly followed by the next start bit is received in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, OVS pulses per bit time |
| rx_line | input | 1 | Serial input, asynchronous to clk |
| fmt | input | 2 | Length: 00 standard (8), 01 short (7), 10 long (9), 11 standard |
| par_en | input | 1 | Parity bit present and checked (short and standard lengths only) |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_stb | input | 1 | One-cycle read strobe that consumes the buffer |
| rd_data | output | 8 | Buffered character, bits 0 to 7 |
| rd_bit9 | output | 1 | Buffered ninth bit in long mode |
| buf_full | output | 1 | Buffer holds an unread character |
| par_err | output | 1 | Parity mismatch on the buffered character |
| ovr_err | output | 1 | A character was overwritten before it was read |
| frm_stat | output | 1 | Stop bit was sampled low and the line has not yet returned high |

## Verification
A character is committed one clock after the stop bit's mid-bit sample. That sample falls about half a bit time plus three clocks (two synchronizer stages and the tick alignment) into the stop bit. The bench therefore reads rd_data and the flags only after the full stop bit has been sent, plus two clocks. Each read strobe is followed by one clock edge before the flags are checked, since their clearing is registered. The framing status is checked while the line is held low, and again six clocks after the line rises, which covers the synchronizer delay plus one register.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [1:0] {
      FMT_STD   = 2'b00,
      FMT_SHORT = 2'b01,
      FMT_LONG  = 2'b10,
      FMT_ALT   = 2'b11
   } rx_fmt_e;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_BITS  = 3'd2,
      RX_STOP  = 3'd3,
      RX_HOLD  = 3'd4
   } rx_state_e;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("serial_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b1;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b1;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxs,
   input  rx_fmt_e           fmt,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              done,
   output logic [DATA_W:0]   char_q,
   output logic              par_bad,
   output logic              frm_stat
);

   localparam int DMAX = DATA_W + 1;
   localparam int CW   = $clog2(OVS);
   localparam int HALF = OVS / 2;
   localparam int IW   = $clog2(DMAX + 2);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("serial_rx_frame: OVS must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("serial_rx_frame: DATA_W must be at least 2");
   end

   rx_state_e       st;
   logic [CW-1:0]   tcnt;
   logic [IW-1:0]   bidx;
   logic [IW-1:0]   ndata;
   logic [IW-1:0]   nbits;
   logic            use_par;
   logic [DMAX-1:0] dat;
   logic            pbit;
   logic            half_hit;
   logic            full_hit;

   always_comb begin
      unique case (fmt)
         FMT_SHORT: ndata = IW'(DATA_W - 1);
         FMT_LONG:  ndata = IW'(DATA_W + 1);
         default:   ndata = IW'(DATA_W);
      endcase
   end

   assign use_par  = par_en && (fmt != FMT_LONG);
   assign nbits    = ndata + IW'(use_par);
   assign half_hit = (tcnt == CW'(HALF - 1));
   assign full_hit = (tcnt == CW'(OVS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= RX_IDLE;
         tcnt     <= '0;
         bidx     <= '0;
         dat      <= '0;
         pbit     <= 1'b0;
         done     <= 1'b0;
         frm_stat <= 1'b0;
      end else begin
         done <= 1'b0;
         if (rxs && st != RX_STOP) frm_stat <= 1'b0;
         unique case (st)
            RX_IDLE: begin
               if (tick && !rxs) begin
                  st   <= RX_START;
                  tcnt <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (half_hit) begin
                     tcnt <= '0;
                     bidx <= '0;
                     dat  <= '0;
                     pbit <= 1'b0;
                     st   <= rxs ? RX_IDLE : RX_BITS;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            RX_BITS: begin
               if (tick) begin
                  if (full_hit) begin
                     tcnt <= '0;
                     if (bidx < ndata) begin
                        for (int i = 0; i < DMAX; i++) begin
                           if (bidx == IW'(i)) dat[i] <= rxs;
                        end
                     end else begin
                        pbit <= rxs;
                     end
                     bidx <= bidx + 1'b1;
                     if (bidx == nbits - 1'b1) st <= RX_STOP;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (full_hit) begin
                     tcnt <= '0;
                     done <= 1'b1;
                     if (rxs) begin
                        st <= RX_IDLE;
                     end else begin
                        st       <= RX_HOLD;
                        frm_stat <= 1'b1;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            RX_HOLD: begin
               if (rxs) st <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   assign char_q  = dat;
   assign par_bad = use_par && ((^dat) ^ pbit ^ par_odd);

   // R3
   sample_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(tick));

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   frm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_stat && rxs) |=> !frm_stat);

   // R9
   frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_stat && !rxs) |=> frm_stat);

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [DATA_W:0] char_d,
   input  logic            pbad_d,
   input  logic            rd_stb,
   output logic [DATA_W:0] buf_q,
   output logic            full,
   output logic            perr,
   output logic            ovr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         full  <= 1'b0;
         perr  <= 1'b0;
         ovr   <= 1'b0;
      end else if (load) begin
         buf_q <= char_d;
         full  <= 1'b1;
         perr  <= pbad_d;
         ovr   <= rd_stb ? 1'b0 : (ovr | full);
      end else if (rd_stb) begin
         full <= 1'b0;
         perr <= 1'b0;
         ovr  <= 1'b0;
      end
   end

   // R7
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !load) |=> (!full && !perr && !ovr));

   // R8
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && full && !rd_stb) |=> ovr);

   // R3
   load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> full);

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
   import serial_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_line,
   input  logic [1:0]        fmt,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_bit9,
   output logic              buf_full,
   output logic              par_err,
   output logic              ovr_err,
   output logic              frm_stat
);

   logic            rxs;
   logic            done;
   logic [DATA_W:0] char_q;
   logic            par_bad;
   logic [DATA_W:0] buf_q;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_line),
      .dout (rxs)
   );

   serial_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .rxs     (rxs),
      .fmt     (rx_fmt_e'(fmt)),
      .par_en  (par_en),
      .par_odd (par_odd),
      .done    (done),
      .char_q  (char_q),
      .par_bad (par_bad),
      .frm_stat(frm_stat)
   );

   serial_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (done),
      .char_d(char_q),
      .pbad_d(par_bad),
      .rd_stb(rd_stb),
      .buf_q (buf_q),
      .full  (buf_full),
      .perr  (par_err),
      .ovr   (ovr_err)
   );

   assign rd_data = buf_q[DATA_W-1:0];
   assign rd_bit9 = buf_q[DATA_W];

   // R5
   long_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fmt == 2'b10) |=> !par_err);

endmodule

// File: tb/serial_frame_rx_test.sv
`timescale 1ns/1ps
module serial_frame_rx_test;

   localparam int BIT_CLKS = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rx_line = 1'b1;
   logic [1:0] fmt = 2'b00;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic       rd_bit9, buf_full, par_err, ovr_err, frm_stat;

   int n_checks = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   initial forever begin
      @(posedge clk);
      tick <= ~tick;
   end

   serial_frame_rx uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
      .fmt(fmt), .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb),
      .rd_data(rd_data), .rd_bit9(rd_bit9), .buf_full(buf_full),
      .par_err(par_err), .ovr_err(ovr_err), .frm_stat(frm_stat)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rx_line = v;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send(input logic [8:0] d, input int nd, input bit wp,
                       input logic pv, input logic stopv);
      @(negedge clk);
      hold_bit(1'b0);
      for (int i = 0; i < nd; i++) hold_bit(d[i]);
      if (wp) hold_bit(pv);
      hold_bit(stopv);
      rx_line = 1'b1;
   endtask

   task automatic do_read();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 buf_full", 16'(buf_full), 0);
      check("R1 flags", {13'd0, par_err, ovr_err, frm_stat}, 0);
      check("R1 data", {7'd0, rd_bit9, rd_data}, 0);
   endtask

   task automatic t_glitch();
      @(negedge clk);
      rx_line = 1'b0;
      repeat (8) @(negedge clk);
      rx_line = 1'b1;
      repeat (20 * BIT_CLKS) @(negedge clk);
      check("R2 no load", 16'(buf_full), 0);
      check("R2 no framing", 16'(frm_stat), 0);
   endtask

   task automatic t_std();
      fmt = 2'b00; par_en = 1'b0;
      send(9'h0A5, 8, 0, 0, 1);
      repeat (2) @(negedge clk);
      check("R3 data", 16'(rd_data), 16'h00A5);
      check("R3 full", 16'(buf_full), 1);
      do_read();
      check("R7 full cleared", 16'(buf_full), 0);
      fmt = 2'b11;
      send(9'h03C, 8, 0, 0, 1);
      repeat (2) @(negedge clk);
      check("R3 alt code data", 16'(rd_data), 16'h003C);
      do_read();
   endtask

   task automatic t_short();
      fmt = 2'b01; par_en = 1'b0;
      send(9'h02B, 7, 0, 0, 1);
      repeat (2) @(negedge clk);
      check("R4 data top zero", 16'(rd_data), 16'h002B);
      do_read();
   endtask

   task automatic t_long();
      fmt = 2'b10; par_en = 1'b1; par_odd = 1'b0;
      send(9'h1C2, 9, 0, 0, 1);
      repeat (2) @(negedge clk);
      check("R5 low byte", 16'(rd_data), 16'h00C2);
      check("R5 ninth bit", 16'(rd_bit9), 1);
      check("R5 no parity", 16'(par_err), 0);
      do_read();
      par_en = 1'b0;
   endtask

   task automatic t_parity();
      fmt = 2'b00; par_en = 1'b1; par_odd = 1'b0;
      send(9'h003, 8, 1, 0, 1);
      repeat (2) @(negedge clk);
      check("R6 even good", 16'(par_err), 0);
      do_read();
      send(9'h003, 8, 1, 1, 1);
      repeat (2) @(negedge clk);
      check("R6 even bad", 16'(par_err), 1);
      check("R6 data kept", 16'(rd_data), 16'h0003);
      do_read();
      check("R7 par_err cleared", 16'(par_err), 0);
      par_odd = 1'b1;
      send(9'h007, 8, 1, 0, 1);
      repeat (2) @(negedge clk);
      check("R6 odd good", 16'(par_err), 0);
      do_read();
      fmt = 2'b01;
      send(9'h007, 7, 1, 1, 1);
      repeat (2) @(negedge clk);
      check("R6 short odd bad", 16'(par_err), 1);
      do_read();
      par_en = 1'b0; par_odd = 1'b0;
   endtask

   task automatic t_overrun();
      fmt = 2'b00;
      send(9'h011, 8, 0, 0, 1);
      send(9'h0E7, 8, 0, 0, 1);
      repeat (2) @(negedge clk);
      check("R10 R8 second char", 16'(rd_data), 16'h00E7);
      check("R8 overrun", 16'(ovr_err), 1);
      do_read();
      check("R7 ovr cleared", 16'(ovr_err), 0);
   endtask

   task automatic t_framing();
      fmt = 2'b00;
      send(9'h05A, 8, 0, 0, 0);
      rx_line = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 frm set", 16'(frm_stat), 1);
      check("R9 char loaded", 16'(rd_data), 16'h005A);
      do_read();
      repeat (3 * BIT_CLKS) @(negedge clk);
      check("R9 frm held", 16'(frm_stat), 1);
      rx_line = 1'b1;
      repeat (6) @(negedge clk);
      check("R9 frm cleared", 16'(frm_stat), 0);
      repeat (12 * BIT_CLKS) @(negedge clk);
      check("R9 no start during low", 16'(buf_full), 0);
   endtask

   initial begin
      bit timed_out = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      fork
         begin
            t_reset();
            t_glitch();
            t_std();
            t_short();
            t_long();
            t_parity();
            t_overrun();
            t_framing();
         end
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule